// File: doc/BRIEF.md
# One-Time Programmable Fuse Array Controller

This block holds a small array of one-time programmable bits used for configuration parameters and identity data. The array is a register file with one-way write semantics. A program cycle ORs new data into the stored bits, so a bit that is 1 stays 1 forever. A request that tries to turn a stored 1 back into 0 has no effect on that bit, and it sets a sticky violation flag. Software can program one byte per request, spread over as many requests as it likes. It can also OR a single data byte into every byte of the array with one bulk request.

After every reset, the controller walks the whole array one byte per clock and copies it into a shadow file. Consumers read the shadow file through a separate combinational port. Register requests are held off until the walk finishes. Register reads return the live array contents. The shadow keeps the image captured at the last reset until the next walk.

Each program request occupies the controller for a fixed number of clocks, and the bits are committed on the last of those clocks. A write-lock input refuses program requests: the array is not touched and a sticky lock-error flag is set.

Top module: `otp_ctrl`

## Requirements
- R1: While reset is asserted, boot_done, req_ready, busy, rsp_valid, viol_flag and lock_err are all 0.
- R2: After reset is released, boot_done rises exactly NBYTES clocks later (768 by default). From then on, cfg_data for every address equals the array byte held at that reset.
- R3: Every byte of an array that has never been programmed reads as 0x00.
- R4: A byte program request (req_write=1, req_bulk=0) leaves the addressed byte equal to its old value ORed with req_wdata. No other byte changes.
- R5: viol_flag is set when a program request's data has a 0 in a position where a targeted stored bit is 1. A request whose data only repeats or adds 1s leaves viol_flag at 0.
- R6: An accepted program request holds busy high for exactly PROG_CYCLES clocks (default 4), and req_ready is 0 while busy is high.
- R7: A bulk program request (req_write=1, req_bulk=1) ORs req_wdata into every byte of the array. Violation detection covers all bytes.
- R8: A program request accepted while wr_lock is 1 leaves the array unchanged, does not raise busy, and sets lock_err.
- R9: A read request (req_write=0) accepted at a clock edge gives rsp_valid=1 after that edge, with rsp_rdata holding the live array byte. cfg_data continues to show the image captured at the last reset.
- R10: viol_flag and lock_err stay set across later clean requests and are cleared only by reset. The array keeps its contents across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restarts the readout walk |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = program, 0 = read |
| req_bulk | input | 1 | With req_write: apply data to every byte |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 8 | Program data, ORed into storage |
| req_ready | output | 1 | Request accepted this edge when high with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data from the live array |
| wr_lock | input | 1 | Refuses program requests when high |
| busy | output | 1 | Program cycle in progress |
| boot_done | output | 1 | Post-reset readout finished |
| viol_flag | output | 1 | Sticky: attempted 1-to-0 change |
| lock_err | output | 1 | Sticky: program request refused by lock |
| cfg_addr | input | 10 | Shadow file address |
| cfg_data | output | 8 | Shadow file byte |

## Verification
The bench checks a write that repeats existing 1s. A design that compared data with the stored bits, rather than looking for stored 1s against data 0s, would flag a violation there. It also checks a write that would clear bits. A design that stored the data directly would show the lost bits on read-back.

Locked writes are checked for three effects: a leaked commit, a busy pulse, and a missing error flag. The shadow file is checked against two faults: updating at commit time instead of on the next reset, and being cleared when the array should persist. Bulk writes are checked at the first address, the last address and interior addresses, and the busy window is counted to catch off-by-one timers.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int unsigned OTP_DATA_W = 8;

    typedef logic [OTP_DATA_W-1:0] otp_byte_t;

    typedef enum logic {
        OTP_OP_READ = 1'b0,
        OTP_OP_PROG = 1'b1
    } otp_op_e;

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
    import otp_pkg::*;
#(
    parameter int unsigned NBYTES = 768,
    localparam int unsigned AW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output otp_byte_t     rd_data,
    input  logic [AW-1:0] walk_addr,
    output otp_byte_t     walk_data,
    input  logic [AW-1:0] chk_addr,
    input  otp_byte_t     chk_data,
    input  logic          chk_bulk,
    output logic          chk_viol,
    input  logic          cm_en,
    input  logic [AW-1:0] cm_addr,
    input  otp_byte_t     cm_data,
    input  logic          cm_bulk
);

    otp_byte_t fuse_q [NBYTES] = '{default: '0};
    logic [NBYTES-1:0] clash;

    assign rd_data   = fuse_q[rd_addr];
    assign walk_data = fuse_q[walk_addr];

    generate
        for (genvar i = 0; i < NBYTES; i++) begin : g_cell
            assign clash[i] = |(fuse_q[i] & ~chk_data);
            always_ff @(posedge clk) begin
                if (cm_en && (cm_bulk || cm_addr == AW'(i))) begin
                    fuse_q[i] <= fuse_q[i] | cm_data;
                end
            end
        end
    endgenerate

    always_comb begin
        if (chk_bulk) chk_viol = |clash;
        else          chk_viol = |(fuse_q[chk_addr] & ~chk_data);
    end

endmodule

// File: rtl/otp_boot_walk.sv
module otp_boot_walk
    import otp_pkg::*;
#(
    parameter int unsigned NBYTES = 768,
    localparam int unsigned AW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] walk_addr,
    input  otp_byte_t     walk_data,
    output logic          done,
    input  logic [AW-1:0] cfg_addr,
    output otp_byte_t     cfg_data
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          done;
    } walk_t;

    walk_t s_d, s_q;
    otp_byte_t shadow_q [NBYTES];

    always_comb begin
        s_d = s_q;
        if (!s_q.done) begin
            if (s_q.ptr == AW'(NBYTES - 1)) s_d.done = 1'b1;
            else                            s_d.ptr  = s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (rst_n && !s_q.done) shadow_q[s_q.ptr] <= walk_data;
    end

    assign walk_addr = s_q.ptr;
    assign done      = s_q.done;
    assign cfg_data  = shadow_q[cfg_addr];

    a_r2_done_stays: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> s_q.done);

    a_r2_ptr_holds_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> $stable(s_q.ptr));

endmodule

// File: rtl/otp_prog_ctl.sv
module otp_prog_ctl
    import otp_pkg::*;
#(
    parameter int unsigned NBYTES      = 768,
    parameter int unsigned PROG_CYCLES = 4,
    localparam int unsigned AW = $clog2(NBYTES),
    localparam int unsigned CW = $clog2(PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_prog,
    input  logic          lock,
    input  logic          viol_now,
    input  logic [AW-1:0] addr,
    input  otp_byte_t     data,
    input  logic          bulk,
    output logic          busy,
    output logic          cm_en,
    output logic [AW-1:0] cm_addr,
    output otp_byte_t     cm_data,
    output logic          cm_bulk,
    output logic          viol_flag,
    output logic          lock_err
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        otp_byte_t     data;
        logic          bulk;
        logic          viol;
        logic          lerr;
    } prog_t;

    prog_t s_d, s_q;
    logic  commit;

    always_comb begin
        s_d    = s_q;
        commit = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                commit   = 1'b1;
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (acc_prog) begin
            if (lock) begin
                s_d.lerr = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.cnt  = CW'(PROG_CYCLES - 1);
                s_d.addr = addr;
                s_d.data = data;
                s_d.bulk = bulk;
                if (viol_now) s_d.viol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign cm_en     = commit;
    assign cm_addr   = s_q.addr;
    assign cm_data   = s_q.data;
    assign cm_bulk   = s_q.bulk;
    assign viol_flag = s_q.viol;
    assign lock_err  = s_q.lerr;

    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> s_q.busy);

    a_r8_lock_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_prog && lock && !s_q.busy) |=> (!s_q.busy && s_q.lerr));

    a_r10_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.viol |=> s_q.viol);

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lerr |=> s_q.lerr);

endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned NBYTES      = 768,
    parameter int unsigned PROG_CYCLES = 4,
    localparam int unsigned AW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_bulk,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [7:0]    rsp_rdata,
    input  logic          wr_lock,
    output logic          busy,
    output logic          boot_done,
    output logic          viol_flag,
    output logic          lock_err,
    input  logic [AW-1:0] cfg_addr,
    output logic [7:0]    cfg_data
);

    typedef struct packed {
        logic      vld;
        otp_byte_t dat;
    } rsp_t;

    rsp_t          r_d, r_q;
    logic          acc, acc_prog, acc_rd, chk_viol;
    logic [AW-1:0] walk_addr, cm_addr;
    otp_byte_t     walk_data, rd_data, cm_data;
    logic          cm_en, cm_bulk;

    assign req_ready = boot_done && !busy;
    assign acc       = req_valid && req_ready;
    assign acc_prog  = acc && (otp_op_e'(req_write) == OTP_OP_PROG);
    assign acc_rd    = acc && (otp_op_e'(req_write) == OTP_OP_READ);

    otp_fuse_array #(.NBYTES(NBYTES)) u_array (
        .clk      (clk),
        .rd_addr  (req_addr),
        .rd_data  (rd_data),
        .walk_addr(walk_addr),
        .walk_data(walk_data),
        .chk_addr (req_addr),
        .chk_data (req_wdata),
        .chk_bulk (req_bulk),
        .chk_viol (chk_viol),
        .cm_en    (cm_en),
        .cm_addr  (cm_addr),
        .cm_data  (cm_data),
        .cm_bulk  (cm_bulk)
    );

    otp_boot_walk #(.NBYTES(NBYTES)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .walk_addr(walk_addr),
        .walk_data(walk_data),
        .done     (boot_done),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data)
    );

    otp_prog_ctl #(.NBYTES(NBYTES), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_prog (acc_prog),
        .lock     (wr_lock),
        .viol_now (chk_viol),
        .addr     (req_addr),
        .data     (req_wdata),
        .bulk     (req_bulk),
        .busy     (busy),
        .cm_en    (cm_en),
        .cm_addr  (cm_addr),
        .cm_data  (cm_data),
        .cm_bulk  (cm_bulk),
        .viol_flag(viol_flag),
        .lock_err (lock_err)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = acc_rd;
        if (acc_rd) r_d.dat = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.vld;
    assign rsp_rdata = r_q.dat;

    a_r2_no_prog_while_booting: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !boot_done && !busy) |=> !busy);

    a_r6_commit_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en |-> busy);

    a_r9_no_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !rsp_valid);

endmodule

// File: tb/otp_ctrl_bench.sv
`timescale 1ns/1ps
module otp_ctrl_bench;

    localparam int NB = 768;
    localparam int PC = 4;
    localparam int AW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_bulk = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          req_ready, rsp_valid, busy, boot_done, viol_flag, lock_err;
    logic [7:0]    rsp_rdata, cfg_data;
    logic          wr_lock = 1'b0;
    logic [AW-1:0] cfg_addr = '0;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [NB];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    otp_ctrl #(.NBYTES(NB), .PROG_CYCLES(PC)) u_otp_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bulk(req_bulk), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .wr_lock(wr_lock), .busy(busy), .boot_done(boot_done),
        .viol_flag(viol_flag), .lock_err(lock_err),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses appear.
    always @(negedge clk) begin
        if (rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected response actual=%0h expected=none", rsp_rdata);
            end else begin
                string t;
                logic [7:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    errors++;
                    $display("FAIL %s read actual=%0h expected=%0h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic issue(input logic wr, input logic bk, input int a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bulk = bk;
        req_addr = AW'(a); req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        exp_q.push_back(model[a]);
        tag_q.push_back(tag);
        issue(1'b0, 1'b0, a, 8'h00);
    endtask

    task automatic prog(input int a, input logic [7:0] d, input logic bk, input string tag);
        int n = 0;
        logic rdy_seen = 1'b0;
        issue(1'b1, bk, a, d);
        if (!wr_lock) begin
            if (bk) begin
                for (int i = 0; i < NB; i++) model[i] = model[i] | d;
            end else begin
                model[a] = model[a] | d;
            end
        end
        @(negedge clk);
        while (busy) begin
            n++;
            if (req_ready) rdy_seen = 1'b1;
            @(negedge clk);
        end
        if (!wr_lock) begin
            check({tag, " R6 busy cycles"}, n, PC);
            check("R6 ready low while busy", int'(rdy_seen), 0);
        end
    endtask

    task automatic do_reset(input string tag);
        int n = 0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({tag, " R1 boot_done"}, int'(boot_done), 0);
        check({tag, " R1 ready"}, int'(req_ready), 0);
        check({tag, " R1 busy/rsp"}, int'(busy | rsp_valid), 0);
        check({tag, " R1 flags"}, int'(viol_flag | lock_err), 0);
        rst_n = 1'b1;
        do begin
            @(negedge clk);
            n++;
        end while (!boot_done && n < 5000);
        check({tag, " R2 boot length"}, n, NB);
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) model[i] = 8'h00;
        do_reset("first");
        rd(0, "R3 addr0"); rd(5, "R3 addr5"); rd(NB - 1, "R3 last");
        cfg_addr = AW'(NB - 1);
        #1 check("R3 cfg blank", int'(cfg_data), 0);

        prog(5, 8'hA5, 1'b0, "R4 first");
        check("R5 clean write no viol", int'(viol_flag), 0);
        rd(5, "R4 A5");
        rd(4, "R4 neighbour");
        prog(5, 8'hA5, 1'b0, "R5 repeat");
        check("R5 repeated ones no viol", int'(viol_flag), 0);
        prog(5, 8'h0F, 1'b0, "R5 clear");
        check("R5 clear attempt viol", int'(viol_flag), 1);
        rd(5, "R4 merged AF");
        prog(NB - 1, 8'h3C, 1'b0, "R4 last");
        rd(NB - 1, "R4 last 3C");
        prog(6, 8'h11, 1'b0, "R10 clean");
        check("R10 viol stays", int'(viol_flag), 1);
        cfg_addr = AW'(5);
        #1 check("R9 shadow keeps boot image", int'(cfg_data), 0);

        wr_lock = 1'b1;
        issue(1'b1, 1'b0, 7, 8'hFF);
        @(negedge clk);
        check("R8 no busy when locked", int'(busy), 0);
        check("R8 lock_err set", int'(lock_err), 1);
        wr_lock = 1'b0;
        rd(7, "R8 array unchanged");
        prog(8, 8'h01, 1'b0, "R10 after lock");
        check("R10 lock_err stays", int'(lock_err), 1);

        do_reset("second");
        cfg_addr = AW'(5);
        #1 check("R2 shadow addr5", int'(cfg_data), 8'hAF);
        cfg_addr = AW'(NB - 1);
        #1 check("R2 shadow last", int'(cfg_data), 8'h3C);
        rd(5, "R10 array kept");

        prog(0, 8'h80, 1'b1, "R7 bulk");
        check("R7 bulk viol", int'(viol_flag), 1);
        rd(0, "R7 first"); rd(5, "R7 addr5"); rd(100, "R7 mid"); rd(NB - 1, "R7 last");
        rd(8, "R7 addr8");

        repeat (3) @(negedge clk);
        check("R9 all responses seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule